// File: doc/BRIEF.md
# Power-Up Strap Capture Controller

This block serves a group of dual-role pads. Each pad is read as a configuration input while the chip powers up, and drives a clock once start-up is over. A power-good input opens a sampling window of a fixed number of reference-clock cycles. For the whole window every pad driver is three-stated and held low, so that an external pull resistor alone sets each pad's level. On the last edge of the window the pad levels are captured. In that same cycle the drivers are enabled and the pads start to carry the clock sources handed in by the clock generator.

Four captured bits form the frequency-select code. The fifth selects the supply mode of the processor clock outputs. Once captured, the values stay put until power-good is removed, which stands for a power cycle. No other input can clear or alter them. The block moves no data stream, so every pin is a plain level with no valid/ready handshake and no back-pressure.

Top module: `strap_capture_ctrl`

## Requirements
- R1: While `pwr_good` is low, `pad_oe` and `pad_out` are all zero, `strap_valid` is 0, and `freq_sel` and `cpu_low_volt` read 0.
- R2: After `pwr_good` rises, `strap_valid` and `pad_oe` stay low through the first WINDOW_CYCLES-1 rising clock edges. They go high right after the WINDOW_CYCLES-th edge.
- R3: During the window every bit of `pad_oe` is 0 and every bit of `pad_out` is 0, whatever `clk_src` does.
- R4: The capture takes the `pad_in` levels present at the WINDOW_CYCLES-th edge. Pad bits 0..3 become `freq_sel[0]`..`freq_sel[3]`. Pad bit 4 becomes `cpu_low_volt`, where 1 means 2.5 V and 0 means 3.3 V operation.
- R5: From the cycle `strap_valid` rises, all five bits of `pad_oe` are 1 and `pad_out` equals `clk_src` bit for bit.
- R6: While `pwr_good` stays high after capture, `freq_sel` and `cpu_low_volt` never change, whatever `pad_in` does.
- R7: If `pwr_good` falls during the window, nothing is captured. On the next rise a full window of WINDOW_CYCLES edges starts again.
- R8: `strap_valid` stays high until `pwr_good` falls. The fall clears it and the captured values at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that times the window |
| pwr_good | input | 1 | Core supply good; low acts as the power-cycle clear (asynchronous) |
| pad_in | input | 5 | Levels seen at the dual-role pads |
| clk_src | input | 5 | Clock waveforms to drive onto the pads after capture |
| pad_oe | output | 5 | Pad driver enables, 1 = driving |
| pad_out | output | 5 | Pad driver data |
| freq_sel | output | 4 | Captured frequency-select code |
| cpu_low_volt | output | 1 | Captured supply mode, 1 = 2.5 V, 0 = 3.3 V |
| strap_valid | output | 1 | Capture done and outputs enabled |

## Verification
The embedded assertions check four things on every clock edge while power is good:
- the window counter stays inside its bound;
- `strap_valid` rises only on the window's last count and then stays high;
- the captured bits hold still once valid;
- the pad enables always match `strap_valid` and are never partly set, and pad data stays low before capture.

The bench scenarios cover what needs an exact stimulus and timing:
- the window length in edges;
- which pad value is taken when the pads change just before the final edge;
- the bit mapping of the code and the supply mode;
- a restart after power-good drops mid-window;
- clearing on a power cycle.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int unsigned FS_WIDTH  = 4;
  localparam int unsigned NUM_PADS  = FS_WIDTH + 1;
  localparam int unsigned VMODE_PAD = FS_WIDTH;

  typedef struct packed {
    logic                low_volt;
    logic [FS_WIDTH-1:0] fsel;
  } strap_cfg_t;

  function automatic strap_cfg_t decode_pads(input logic [NUM_PADS-1:0] lv);
    strap_cfg_t c;
    c.fsel     = lv[FS_WIDTH-1:0];
    c.low_volt = lv[VMODE_PAD];
    return c;
  endfunction
endpackage

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
  parameter int unsigned WINDOW_CYCLES = 28636
) (
  input  logic clk,
  input  logic pwr_good,
  output logic capture_now,
  output logic window_done
);
  localparam int unsigned CW = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          done_q;

  assign capture_now = !done_q && (cnt == LAST);
  assign window_done = done_q;

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      cnt    <= '0;
      done_q <= 1'b0;
    end else if (capture_now) begin
      done_q <= 1'b1;
    end else if (!done_q) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    cnt <= LAST);
  // R2
  done_on_last_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(done_q) |-> $past(cnt) == LAST);
  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    done_q |=> done_q);
endmodule

// File: rtl/strap_latch_bank.sv
module strap_latch_bank
  import strap_pkg::*;
#(
  parameter int unsigned N = NUM_PADS
) (
  input  logic         clk,
  input  logic         pwr_good,
  input  logic         capture,
  input  logic         held,
  input  logic [N-1:0] level,
  output logic [N-1:0] bits
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge pwr_good) begin
      if (!pwr_good)    bits[i] <= 1'b0;
      else if (capture) bits[i] <= level[i];
    end
  end

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    held |=> $stable(bits));
  // R7
  no_early_capture_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    (!held && !capture) |=> bits == '0);
endmodule

// File: rtl/strap_pad_mux.sv
module strap_pad_mux #(
  parameter int unsigned N = 5
) (
  input  logic         enable,
  input  logic [N-1:0] clk_src,
  output logic [N-1:0] oe,
  output logic [N-1:0] dout
);
  for (genvar i = 0; i < N; i++) begin : g_pad
    assign oe[i]   = enable;
    assign dout[i] = enable & clk_src[i];
  end
endmodule

// File: rtl/strap_capture_ctrl.sv
module strap_capture_ctrl
  import strap_pkg::*;
#(
  parameter int unsigned WINDOW_CYCLES = 28636
) (
  input  logic                clk,
  input  logic                pwr_good,
  input  logic [NUM_PADS-1:0] pad_in,
  input  logic [NUM_PADS-1:0] clk_src,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [FS_WIDTH-1:0] freq_sel,
  output logic                cpu_low_volt,
  output logic                strap_valid
);
  logic                capture_now;
  logic                window_done;
  logic [NUM_PADS-1:0] latched;
  strap_cfg_t          cfg;

  strap_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk         (clk),
    .pwr_good    (pwr_good),
    .capture_now (capture_now),
    .window_done (window_done)
  );

  strap_latch_bank #(.N(NUM_PADS)) u_latch (
    .clk      (clk),
    .pwr_good (pwr_good),
    .capture  (capture_now),
    .held     (window_done),
    .level    (pad_in),
    .bits     (latched)
  );

  strap_pad_mux #(.N(NUM_PADS)) u_pads (
    .enable  (window_done),
    .clk_src (clk_src),
    .oe      (pad_oe),
    .dout    (pad_out)
  );

  assign cfg          = decode_pads(latched);
  assign freq_sel     = cfg.fsel;
  assign cpu_low_volt = cfg.low_volt;
  assign strap_valid  = window_done;

  // R5
  oe_follows_valid_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    pad_oe == {NUM_PADS{strap_valid}});
  // R3
  quiet_window_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    !strap_valid |-> (pad_out == '0));
endmodule

// File: tb/tb_strap_capture_ctrl.sv
module tb_strap_capture_ctrl;
  localparam int W = 20;

  logic       clk = 1'b0;
  logic       pwr_good = 1'b0;
  logic [4:0] pad_in = '0;
  logic [4:0] clk_src = '0;
  logic [4:0] pad_oe, pad_out;
  logic [3:0] freq_sel;
  logic       cpu_low_volt, strap_valid;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  strap_capture_ctrl #(.WINDOW_CYCLES(W)) dut (
    .clk(clk), .pwr_good(pwr_good), .pad_in(pad_in), .clk_src(clk_src),
    .pad_oe(pad_oe), .pad_out(pad_out), .freq_sel(freq_sel),
    .cpu_low_volt(cpu_low_volt), .strap_valid(strap_valid));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic power_off();
    @(negedge clk); pwr_good = 1'b0;
    @(negedge clk);
  endtask

  // raise power, run W edges with given strap levels, check edge timing
  task automatic power_up(input logic [4:0] straps);
    @(negedge clk); pad_in = straps; pwr_good = 1'b1;
    repeat (W-1) @(posedge clk);
    @(negedge clk);
    chk("R2 valid low before last edge", strap_valid, 0);
    chk("R3 oe low in window", pad_oe, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R2 valid after last edge", strap_valid, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 oe", pad_oe, 0);
    chk("R1 out", pad_out, 0);
    chk("R1 valid", strap_valid, 0);
    chk("R1 fs", freq_sel, 0);
    chk("R1 volt", cpu_low_volt, 0);
  endtask

  task automatic t_capture(input logic [4:0] s);
    power_up(s);
    chk("R4 freq_sel", freq_sel, s[3:0]);
    chk("R4 cpu_low_volt", cpu_low_volt, s[4]);
    chk("R5 oe all", pad_oe, 5'h1f);
    clk_src = 5'h0a; #1;
    chk("R5 out follows", pad_out, 5'h0a);
    clk_src = 5'h15; #1;
    chk("R5 out follows 2", pad_out, 5'h15);
    power_off();
  endtask

  task automatic t_window_quiet();
    @(negedge clk); pad_in = 5'h1f; clk_src = 5'h1f; pwr_good = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk("R3 out held low", pad_out, 0);
      chk("R3 oe off", pad_oe, 0);
    end
    power_off();
  endtask

  task automatic t_last_edge();
    @(negedge clk); pad_in = 5'h03; pwr_good = 1'b1;
    repeat (W-1) @(posedge clk);
    @(negedge clk); pad_in = 5'h1c;
    @(negedge clk);
    chk("R4 takes last-edge level", freq_sel, 4'hc);
    chk("R4 last-edge volt", cpu_low_volt, 1);
    power_off();
  endtask

  task automatic t_ignore_after();
    power_up(5'h16);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); pad_in = 5'(k * 7);
    end
    @(negedge clk);
    chk("R6 fs held", freq_sel, 4'h6);
    chk("R6 volt held", cpu_low_volt, 1);
    chk("R8 valid stays", strap_valid, 1);
    power_off();
    chk("R8 cleared valid", strap_valid, 0);
    chk("R8 cleared fs", freq_sel, 0);
    chk("R8 cleared volt", cpu_low_volt, 0);
    chk("R1 oe after drop", pad_oe, 0);
  endtask

  task automatic t_dropout();
    @(negedge clk); pad_in = 5'h1b; pwr_good = 1'b1;
    repeat (W-3) @(negedge clk);
    pwr_good = 1'b0;
    @(negedge clk);
    chk("R7 nothing latched", {cpu_low_volt, freq_sel}, 0);
    chk("R7 valid low", strap_valid, 0);
    power_up(5'h09);
    chk("R7 restart fs", freq_sel, 4'h9);
    chk("R7 restart volt", cpu_low_volt, 0);
    power_off();
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_capture(5'h00);
        t_capture(5'h1f);
        t_capture(5'h05);
        t_capture(5'h1a);
        t_window_quiet();
        t_last_edge();
        t_ignore_after();
        t_dropout();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule